// File: doc/BRIEF.md
# Serial Conversion-Result Reader

This block is the clock-owning controller for a delta-sigma converter that is a slave only. The converter has one output line and no serial input. That line first tells the controller that a result is ready, then carries the result bits. The controller never sends data. It only produces clock pulses and listens on the line.

A client raises a one-cycle request together with a two-bit mode. The controller then waits for the line to fall from high to low, which marks a finished conversion. It issues 24 clock pulses and collects the result most significant bit first. The assembled word is presented with a single-cycle valid strobe.

The mode sets the length of the frame:
- Plain read stops after the 24 data pulses.
- Force-high adds a 25th pulse, which drives the converter's line high so it can be polled for the next ready edge.
- Calibrate adds a 25th and a 26th pulse, which start a self-calibration. After that, the controller refuses new work and ignores the line for a fixed holdoff time.

Top module: `adc_rd_master`

## Requirements
- R1: After reset, `sclk_o`, `busy_o` and `valid_o` are all low.
- R2: `sclk_o` stays low whenever no frame is in progress. A falling edge on `dout_i` with no accepted request produces no clock pulse and leaves `busy_o` low.
- R3: A request (`req_i` high for a cycle) is accepted only while `busy_o` is low. Once accepted, `busy_o` is high from the next cycle until the frame, and any holdoff, have ended. A request made while `busy_o` is high is ignored and starts no later frame.
- R4: After a request is accepted, the first clock pulse follows only a high-to-low transition of `dout_i` that occurs after the acceptance. A line that was already low when the request came does not start a frame until it has gone high and then fallen again.
- R5: Each high phase of `sclk_o` lasts exactly `HALF_CYC` system clocks. Each low phase between two pulses of one frame also lasts exactly `HALF_CYC` system clocks.
- R6: Data bit k (k = 1 for the first pulse) is the `dout_i` level after the k-th rising edge of `sclk_o`, sampled at the end of the following low phase. Bit 1 lands in bit 23 of `data_o` and bit 24 in bit 0.
- R7: `valid_o` is high for exactly one cycle per frame. It comes after the 24th falling edge of `sclk_o` and before any further falling edge. `data_o` holds the full result in that cycle.
- R8: The mode is taken from `mode_i` when the request is accepted, and sets the number of pulses in the frame. The encodings are 0 = read (24 pulses), 1 = force-high (25 pulses), 2 = calibrate (26 pulses), and 3 = read (24 pulses).
- R9: `busy_o` falls `HALF_CYC` system clocks after the last falling edge of `sclk_o`. In calibrate mode it falls `HALF_CYC + HOLDOFF` clocks after that edge. During that holdoff, activity on `dout_i` and on `req_i` starts nothing.
- R10: Level changes on `dout_i` while a frame is running are never taken as ready events. A frame has exactly the pulse count of its mode, and the next request waits for a fresh fall of the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request to read one result |
| mode_i | input | 2 | Frame mode, sampled with the request |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| dout_i | input | 1 | Shared ready and data line from the converter |
| data_o | output | DATA_W | Assembled result, MSB first |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | High from request acceptance to frame or holdoff end |

## Verification
The bench builds the block with `HALF_CYC = 2`, the smallest phase allowed. In that configuration the two-flop synchronizer delay uses up almost the whole sampling margin, so a sample taken one cycle too early or too late shows up as a wrong result bit. That setting also makes the valid strobe coincide with the rising edge of the extra pulse, which tests the ordering rule for the strobe. `HOLDOFF = 40` is short enough to run many calibrate frames. It is also long enough that the bench can inject a request and a line fall inside the holdoff and observe that neither one starts anything.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_FORCE = 2'd1,
      MODE_CAL   = 2'd2,
      MODE_ALT   = 2'd3
   } rd_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_HIGH,
      ST_LOW,
      ST_HOLD
   } rd_state_e;

   // pulses appended after the data word for each mode
   function automatic int unsigned extra_pulses(input rd_mode_e m);
      case (m)
         MODE_FORCE: return 1;
         MODE_CAL:   return 2;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o,
   output logic fall_o
);

   logic [STAGES-1:0] pipe_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("adc_rd_sync: STAGES must be at least 2");
      end
      else if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[0], din};
         end
      end
      else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pipe_q[STAGES-1];
   end

   assign level_o = pipe_q[STAGES-1];
   assign fall_o  = prev_q & ~pipe_q[STAGES-1];

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_o <= '0;
      else if (en) word_o <= {word_o[WIDTH-2:0], bit_i};
   end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
   import adc_rd_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int HALF_CYC = 4,
   parameter int HOLDOFF  = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic [1:0] mode_i,
   input  logic       ready_fall,
   output logic       sclk_o,
   output logic       busy_o,
   output logic       sample_en,
   output logic       valid_o
);

   localparam int CW = $clog2(HALF_CYC);
   localparam int PW = $clog2(DATA_W + 3);
   localparam int HW = $clog2(HOLDOFF + 1);

   rd_state_e       state_q;
   logic [CW-1:0]   cnt_q;
   logic [PW-1:0]   pcnt_q;
   logic [PW-1:0]   total_q;
   logic [HW-1:0]   hcnt_q;
   logic            cal_q;
   logic            valid_q;
   logic            phase_end;
   logic [PW-1:0]   pulse_next;
   rd_mode_e        mode_e;

   assign mode_e     = rd_mode_e'(mode_i);
   assign phase_end  = (cnt_q == CW'(HALF_CYC - 1));
   assign pulse_next = pcnt_q + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         pcnt_q  <= '0;
         total_q <= '0;
         hcnt_q  <= '0;
         cal_q   <= 1'b0;
         valid_q <= 1'b0;
      end
      else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  state_q <= ST_WAIT;
                  cal_q   <= (mode_e == MODE_CAL);
                  total_q <= PW'(DATA_W + int'(extra_pulses(mode_e)));
               end
            end
            ST_WAIT: begin
               if (ready_fall) begin
                  state_q <= ST_HIGH;
                  cnt_q   <= '0;
                  pcnt_q  <= '0;
               end
            end
            ST_HIGH: begin
               if (phase_end) begin
                  state_q <= ST_LOW;
                  cnt_q   <= '0;
               end
               else cnt_q <= cnt_q + CW'(1);
            end
            ST_LOW: begin
               if (phase_end) begin
                  cnt_q  <= '0;
                  pcnt_q <= pulse_next;
                  if (pulse_next == PW'(DATA_W)) valid_q <= 1'b1;
                  if (pulse_next == total_q) begin
                     state_q <= cal_q ? ST_HOLD : ST_IDLE;
                     hcnt_q  <= '0;
                  end
                  else state_q <= ST_HIGH;
               end
               else cnt_q <= cnt_q + CW'(1);
            end
            ST_HOLD: begin
               if (hcnt_q == HW'(HOLDOFF - 1)) state_q <= ST_IDLE;
               else                             hcnt_q  <= hcnt_q + HW'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk_o    = (state_q == ST_HIGH);
   assign busy_o    = (state_q != ST_IDLE);
   assign sample_en = (state_q == ST_LOW) && phase_end && (pcnt_q < PW'(DATA_W));
   assign valid_o   = valid_q;

endmodule

// File: rtl/adc_rd_master.sv
module adc_rd_master #(
   parameter int DATA_W      = 24,
   parameter int HALF_CYC    = 4,
   parameter int HOLDOFF     = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [1:0]        mode_i,
   output logic              sclk_o,
   input  logic              dout_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              busy_o
);

   generate
      if (HALF_CYC < 2) begin : g_chk_half
         $error("adc_rd_master: HALF_CYC must be at least 2");
      end
      if (DATA_W < 2) begin : g_chk_width
         $error("adc_rd_master: DATA_W must be at least 2");
      end
      if (HOLDOFF < 1) begin : g_chk_hold
         $error("adc_rd_master: HOLDOFF must be at least 1");
      end
   endgenerate

   logic line_s;
   logic line_fall;
   logic sample_en;
   logic ctrl_busy;
   logic ready_fall;

   adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (dout_i),
      .level_o (line_s),
      .fall_o  (line_fall)
   );

   // ready events only count while a request waits; the controller
   // masks them itself in every other state
   assign ready_fall = line_fall & ctrl_busy;

   adc_rd_ctrl #(
      .DATA_W   (DATA_W),
      .HALF_CYC (HALF_CYC),
      .HOLDOFF  (HOLDOFF)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .mode_i     (mode_i),
      .ready_fall (ready_fall),
      .sclk_o     (sclk_o),
      .busy_o     (ctrl_busy),
      .sample_en  (sample_en),
      .valid_o    (valid_o)
   );

   adc_rd_shift #(.WIDTH(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (sample_en),
      .bit_i  (line_s),
      .word_o (data_o)
   );

   assign busy_o = ctrl_busy;

endmodule

// File: rtl/adc_rd_master_chk.sv
module adc_rd_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req_i,
   input logic sclk_o,
   input logic valid_o,
   input logic busy_o
);

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sclk_o) else $error("sclk high while idle"); // R2

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> busy_o) else $error("request not accepted"); // R3

   AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> busy_o) else $error("pulse outside frame"); // R4

   AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk_o) |-> $past(sclk_o, 2)) else $error("high phase too short"); // R5

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R7

   AST_VALID_NOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !$past(sclk_o)) else $error("valid during high phase"); // R7

endmodule

bind adc_rd_master adc_rd_master_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .sclk_o  (sclk_o),
   .valid_o (valid_o),
   .busy_o  (busy_o)
);

// File: tb/adc_rd_master_tb.sv
`timescale 1ns/1ps
module adc_rd_master_tb;

   localparam int W    = 24;
   localparam int HALF = 2;
   localparam int HOLD = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic          sclk_o;
   logic          dout_i = 1'b1;
   logic [W-1:0]  data_o;
   logic          valid_o;
   logic          busy_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   adc_rd_master #(.DATA_W(W), .HALF_CYC(HALF), .HOLDOFF(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
      .sclk_o(sclk_o), .dout_i(dout_i), .data_o(data_o),
      .valid_o(valid_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_pulses(input logic [1:0] m);
      if (m == 2'd1) return 25;
      if (m == 2'd2) return 26;
      return 24;
   endfunction

   // converter model: next bit appears shortly after each rising clock edge
   logic [W-1:0] s_word = '0;
   int s_idx = 0;
   always @(posedge sclk_o) begin
      #1;
      s_idx++;
      if (s_idx <= W) dout_i = s_word[W - s_idx];
      else            dout_i = 1'b1;
   end

   // monitor
   int rises = 0, falls = 0, valids = 0, hi_run = 0, lo_run = 0;
   int since_fall = 0, falls_at_valid = 0;
   logic [W-1:0] got = '0;
   logic prev_sclk = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_o && !prev_sclk) begin
            rises++;
            if (rises > 1) chk(lo_run == HALF, "R5", lo_run, HALF);
            hi_run = 1;
         end
         else if (sclk_o) hi_run++;
         if (!sclk_o && prev_sclk) begin
            falls++;
            chk(hi_run == HALF, "R5", hi_run, HALF);
            lo_run = 1;
            since_fall = 0;
         end
         else begin
            if (!sclk_o) lo_run++;
            since_fall++;
         end
         if (valid_o) begin
            valids++;
            got = data_o;
            falls_at_valid = falls;
         end
         prev_sclk = sclk_o;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic do_frame(input logic [1:0] m, input logic [W-1:0] word,
                           input int lead, input bit poke);
      int n;
      bit poked;
      n = 0;
      poked = 0;
      rises = 0; falls = 0; valids = 0;
      s_word = word;
      s_idx = 0;
      req_i = 1'b1; mode_i = m;
      tick();
      req_i = 1'b0;
      chk(busy_o == 1'b1, "R3", busy_o, 1);
      repeat (lead) tick();
      if (dout_i == 1'b0) begin
         tick(); tick(); tick();
         chk(rises == 0, "R4", rises, 0);
         dout_i = 1'b1;
         tick(); tick(); tick();
      end
      chk(rises == 0, "R10", rises, 0);
      dout_i = 1'b0;
      while (busy_o && n < 3000) begin
         tick();
         n++;
         if (poke && !poked && falls == 26 && since_fall > 3 && busy_o) begin
            req_i = 1'b1; mode_i = 2'd0;
            tick();
            req_i = 1'b0;
            dout_i = 1'b0;
            tick(); tick(); tick(); tick();
            dout_i = 1'b1;
            poked = 1;
            chk(rises == 26, "R9", rises, 26);
         end
      end
      chk(n < 3000, "R3", n, 3000);
      chk(rises == exp_pulses(m), "R8", rises, exp_pulses(m));
      chk(valids == 1, "R7", valids, 1);
      chk(falls_at_valid == W, "R7", falls_at_valid, W);
      chk(got == word, "R6", got, word);
      chk(since_fall == HALF + ((m == 2'd2) ? HOLD : 0), "R9", since_fall,
          HALF + ((m == 2'd2) ? HOLD : 0));
      chk(sclk_o == 1'b0, "R2", sclk_o, 0);
      if (poke) begin
         repeat (20) tick();
         chk(rises == 26 && busy_o == 1'b0, "R3", rises, 26);
      end
   endtask

   initial begin
      #900000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      chk(sclk_o == 1'b0, "R1", sclk_o, 0);
      chk(busy_o == 1'b0, "R1", busy_o, 0);
      chk(valid_o == 1'b0, "R1", valid_o, 0);
      rst_n = 1'b1;
      repeat (5) tick();

      // fall with no request: ignored
      rises = 0;
      dout_i = 1'b0;
      repeat (10) tick();
      dout_i = 1'b1;
      repeat (10) tick();
      chk(rises == 0 && busy_o == 1'b0, "R2", rises, 0);

      // line already low before the request
      dout_i = 1'b0;
      repeat (4) tick();
      do_frame(2'd0, 24'hA5A5A5, 6, 0);
      do_frame(2'd0, 24'hFFFFFF, 2, 0);
      do_frame(2'd1, 24'h000000, 0, 0);
      do_frame(2'd2, 24'h800001, 3, 0);
      do_frame(2'd3, 24'h7FFFFE, 1, 0);
      // line ends low after an even word: next request needs a fresh fall
      do_frame(2'd0, 24'h123456, 0, 0);
      do_frame(2'd2, 24'h5A5A5A, 2, 1);

      for (int i = 0; i < 40; i++) begin
         logic [1:0]   m;
         logic [W-1:0] w;
         m = 2'($urandom_range(0, 3));
         w = W'($urandom);
         do_frame(m, w, int'($urandom_range(0, 10)), (m == 2'd2) && ($urandom_range(0, 1) == 1));
         repeat (int'($urandom_range(0, 5))) tick();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule